// File: doc/BRIEF.md
# Management Frame Master

This block is the serial master for the two-wire PHY management bus. A single command names a PHY address, a register number, a direction and, for writes, a 16-bit value. The block then builds the whole frame on a clock line that it generates and on a data line with a separate output enable, so the data pin can be shared through a tristate buffer. When the frame has finished, the block raises `done` for one cycle. After a read, the 16 returned bits appear on `rd_data`.

The management clock comes from the system clock. A programmable value sets its half-period in system cycles, and that value is captured when a command is accepted. Output bits change only while the management clock is low. Read bits are taken at the end of the clock's high half. Every frame ends with one extra clock in which the line is released. A read frame lasts 64 bit times and a write frame lasts 65.

Top module: `mgmt_frame_master`

## Requirements
- R1: While reset is held, and after it, `mdc`, `mdo`, `mdo_en`, `busy` and `done` are 0 and `rd_data` is 0.
- R2: Bit times 0 to 31 of every frame are driven ones. Bit times 32 and 33 are driven 0 then 1.
- R3: Bit times 34 and 35 carry the opcode. It is driven 1,0 for a read (`cmd_write`=0) and 0,1 for a write (`cmd_write`=1).
- R4: Bit times 36 to 40 carry `cmd_phy` and bit times 41 to 45 carry `cmd_reg`, each driven most significant bit first.
- R5: In a write, bit times 46 and 47 have `mdo_en`=0 and `mdo`=0. Bit times 48 to 63 then drive `cmd_wdata` most significant bit first.
- R6: In a read, bit time 46 is released. In bit times 47 to 62 the line stays released while `mdi` is sampled at the end of each high half, and these 16 bits form `rd_data` most significant bit first.
- R7: The last bit time of a frame is released. A read frame has 64 bit times and a write frame has 65.
- R8: Each high and low half of `mdc` lasts `half_div` system cycles, or 1 cycle when `half_div` is 0, using the value captured when the command was accepted. `mdo` and `mdo_en` do not change while `mdc` is high.
- R9: `done` is high for exactly one cycle, in the cycle after the last high half ends. `busy` falls in that same cycle, and the lines return to `mdc`=0, `mdo`=0, `mdo_en`=0.
- R10: A `cmd_valid` pulse while `busy` is 1 is ignored. The frame in progress is unchanged and no extra frame or `done` follows.
- R11: A command presented in the cycle that `done` is high is accepted and starts a new frame at once.
- R12: A write frame leaves `rd_data` at the value of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number |
| cmd_wdata | input | 16 | Data for a write frame |
| half_div | input | 16 | Management clock half-period in system cycles (0 acts as 1) |
| mdi | input | 1 | Data line as seen at the pin |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rd_data | output | 16 | Data captured by the last read frame |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data driven onto the line |
| mdo_en | output | 1 | Output enable for the data tristate |

## Verification
Two events can fall in the same cycle: the end of one frame, marked by the `done` pulse, and the acceptance of the next command. The bench waits until it sees `done` high and then presents a new command in that same cycle. The scoreboard judges the result. Both frames must come out complete and in order, each with the expected number of bit times, the expected bit pattern and the expected `rd_data`. There must be no gap, no merged frame and no extra `done`. A second kind of overlap is also tested: a command strobe arriving in the middle of a frame. Here the only correct outcome is a single frame whose contents are undisturbed.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int PRE_LEN  = 32;
    localparam int FLD_W    = 5;
    localparam int WORD_W   = 16;
    localparam int HDR_END  = PRE_LEN + 4 + 2 * FLD_W;
    localparam int RD_DATA0 = HDR_END + 1;
    localparam int WR_DATA0 = HDR_END + 2;
    localparam int RD_LAST  = RD_DATA0 + WORD_W;
    localparam int WR_LAST  = WR_DATA0 + WORD_W;
    localparam int FRAME_N  = WR_LAST + 1;
    localparam int IDX_W    = $clog2(FRAME_N);

    typedef struct packed {
        logic en;
        logic val;
        logic smp;
    } bit_drv_t;
endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim      = (div == '0) ? DIV_W'(1) : div;
        half_end = run && (cnt_q == lim - DIV_W'(1));
        if (restart || !run || half_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mgmt_bit_encoder.sv
module mgmt_bit_encoder
    import mgmt_pkg::*;
(
    input  logic              wr,
    input  logic [FLD_W-1:0]  phy,
    input  logic [FLD_W-1:0]  regn,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  idx,
    output bit_drv_t          drv
);
    // Forward vectors hold bit time 0 in their MSB.
    logic [WR_LAST:0] w_val_f, w_en_f, r_val_f, r_en_f, r_smp_f;
    logic [WR_LAST:0] w_val, w_en, r_val, r_en, r_smp;

    assign w_val_f = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phy, regn, 2'b00, wdata, 1'b0};
    assign w_en_f  = {{HDR_END{1'b1}}, 2'b00, {WORD_W{1'b1}}, 1'b0};
    assign r_val_f = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phy, regn, 1'b0, {WORD_W{1'b0}}, 2'b00};
    assign r_en_f  = {{HDR_END{1'b1}}, {(FRAME_N-HDR_END){1'b0}}};
    assign r_smp_f = {{RD_DATA0{1'b0}}, {WORD_W{1'b1}}, 2'b00};

    for (genvar b = 0; b <= WR_LAST; b++) begin : g_rev
        assign w_val[b] = w_val_f[WR_LAST-b];
        assign w_en[b]  = w_en_f[WR_LAST-b];
        assign r_val[b] = r_val_f[WR_LAST-b];
        assign r_en[b]  = r_en_f[WR_LAST-b];
        assign r_smp[b] = r_smp_f[WR_LAST-b];
    end

    always_comb begin
        if (wr) begin
            drv.en  = w_en[idx];
            drv.val = w_val[idx];
            drv.smp = 1'b0;
        end else begin
            drv.en  = r_en[idx];
            drv.val = r_val[idx];
            drv.smp = r_smp[idx];
        end
    end
endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = shift_en ? {data_q[W-2:0], bit_in} : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data = data_q;
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [FLD_W-1:0]  cmd_phy,
    input  logic [FLD_W-1:0]  cmd_reg,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              mdi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_en
);
    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [FLD_W-1:0]  phy;
        logic [FLD_W-1:0]  regn;
        logic [WORD_W-1:0] wdata;
        logic [DIV_W-1:0]  div;
        logic [IDX_W-1:0]  idx;
        logic              high;
        logic              done;
    } seq_t;

    seq_t             st_d, st_q;
    logic             accept;
    logic             half_end;
    logic             sample_en;
    logic [IDX_W-1:0] last_idx;
    bit_drv_t         drv;

    mgmt_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (st_q.busy),
        .div      (st_q.div),
        .half_end (half_end)
    );

    mgmt_bit_encoder u_enc (
        .wr    (st_q.wr),
        .phy   (st_q.phy),
        .regn  (st_q.regn),
        .wdata (st_q.wdata),
        .idx   (st_q.idx),
        .drv   (drv)
    );

    mgmt_rx_shift #(.W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .bit_in   (mdi),
        .data     (rd_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = cmd_valid && !st_q.busy;
        last_idx  = st_q.wr ? IDX_W'(WR_LAST) : IDX_W'(RD_LAST);
        sample_en = st_q.busy && st_q.high && half_end && drv.smp;

        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.wr    = cmd_write;
            st_d.phy   = cmd_phy;
            st_d.regn  = cmd_reg;
            st_d.wdata = cmd_wdata;
            st_d.div   = half_div;
            st_d.idx   = '0;
            st_d.high  = 1'b0;
        end else if (st_q.busy && half_end) begin
            if (!st_q.high) begin
                st_d.high = 1'b1;
            end else if (st_q.idx == last_idx) begin
                st_d.busy = 1'b0;
                st_d.high = 1'b0;
                st_d.idx  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx  = st_q.idx + IDX_W'(1);
                st_d.high = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign mdc    = st_q.busy && st_q.high;
    assign mdo_en = st_q.busy && drv.en;
    assign mdo    = st_q.busy && drv.en && drv.val;
endmodule

// File: rtl/mgmt_frame_master_chk.sv
module mgmt_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdo,
    input logic mdo_en
);
    assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo && !mdo_en));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_lines_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_en)));

    assert_frame_starts_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mdc);

    assert_accept_when_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy && mdc) |=> (busy || done));
endmodule

bind mgmt_frame_master mgmt_frame_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdo       (mdo),
    .mdo_en    (mdo_en)
);

// File: tb/mgmt_frame_master_bench.sv
module mgmt_frame_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] half_div = 16'd2;
    logic        mdi = 1'b0;
    logic        busy, done, mdc, mdo, mdo_en;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    mgmt_frame_master u_mgmt_frame_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .half_div(half_div), .mdi(mdi), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en)
    );

    typedef struct {
        bit        wr;
        bit [4:0]  phy;
        bit [4:0]  regn;
        bit [15:0] wdata;
        bit [15:0] reply;
        int        div;
        bit [15:0] exp_rd;
    } item_t;

    item_t     q[$];
    int        n_cmp = 0;
    int        n_bad = 0;
    bit [15:0] model_rd = '0;
    bit        finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int build(input item_t it, output bit en[65], output bit val[65]);
        int k = 0;
        for (int i = 0; i < 65; i++) begin en[i] = 0; val[i] = 0; end
        for (int i = 0; i < 32; i++) begin en[k] = 1; val[k] = 1; k++; end
        en[k] = 1; val[k] = 0; k++;
        en[k] = 1; val[k] = 1; k++;
        en[k] = 1; val[k] = !it.wr; k++;
        en[k] = 1; val[k] = it.wr; k++;
        for (int i = 4; i >= 0; i--) begin en[k] = 1; val[k] = it.phy[i]; k++; end
        for (int i = 4; i >= 0; i--) begin en[k] = 1; val[k] = it.regn[i]; k++; end
        if (it.wr) begin
            k += 2;
            for (int i = 15; i >= 0; i--) begin en[k] = 1; val[k] = it.wdata[i]; k++; end
        end else begin
            k += 17;
        end
        k += 1;
        return k;
    endfunction

    function automatic string tag(input int i, input bit wr, input int n);
        if (i < 34)     return "R2";
        if (i < 36)     return "R3";
        if (i < 46)     return "R4";
        if (i == n - 1) return "R7";
        return wr ? "R5" : "R6";
    endfunction

    // Monitor and PHY model: scoreboard side.
    initial begin
        int    rises = 0;
        int    hi_len = 0;
        bit    prev_mdc = 0;
        bit    cap_en[65];
        bit    cap_val[65];
        bit    e_en[65];
        bit    e_val[65];
        int    n;
        int    exp_hi;
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rises = 0; prev_mdc = 0; mdi = 0;
                continue;
            end
            if (mdc && !prev_mdc) begin
                if (rises < 65) begin cap_en[rises] = mdo_en; cap_val[rises] = mdo; end
                rises++;
                hi_len = 1;
            end else if (mdc) begin
                hi_len++;
            end else if (prev_mdc && q.size() > 0) begin
                exp_hi = (q[0].div == 0) ? 1 : q[0].div;
                if (hi_len != exp_hi) check(0, "R8", "mdc high length", hi_len, exp_hi);
            end
            prev_mdc = mdc;
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R10", "done with no command pending", 1, 0);
                end else begin
                    it = q.pop_front();
                    n  = build(it, e_en, e_val);
                    check(rises == n, "R7", "bit times in frame", rises, n);
                    for (int i = 0; i < n && i < 65; i++) begin
                        check(cap_en[i] == e_en[i] && cap_val[i] == e_val[i],
                              tag(i, it.wr, n), $sformatf("bit %0d en/val", i),
                              {cap_en[i], cap_val[i]}, {e_en[i], e_val[i]});
                    end
                    check(rd_data == it.exp_rd, it.wr ? "R12" : "R6", "rd_data",
                          rd_data, it.exp_rd);
                end
                rises = 0;
            end
            mdi = 0;
            if (q.size() > 0 && !q[0].wr && rises >= 48 && rises <= 63)
                mdi = q[0].reply[15 - (rises - 48)];
        end
    end

    task automatic send_now(input bit wr, input bit [4:0] phy, input bit [4:0] regn,
                            input bit [15:0] wdata, input bit [15:0] reply, input int div);
        item_t it;
        it.wr = wr; it.phy = phy; it.regn = regn; it.wdata = wdata;
        it.reply = reply; it.div = div;
        if (!wr) model_rd = reply;
        it.exp_rd = model_rd;
        q.push_back(it);
        cmd_write = wr; cmd_phy = phy; cmd_reg = regn; cmd_wdata = wdata;
        half_div = 16'(div); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send(input bit wr, input bit [4:0] phy, input bit [4:0] regn,
                        input bit [15:0] wdata, input bit [15:0] reply, input int div);
        @(negedge clk);
        while (busy) @(negedge clk);
        send_now(wr, phy, regn, wdata, reply, div);
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!mdc && !mdo && !mdo_en, "R1", "lines in reset", {mdc, mdo, mdo_en}, 0);
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        check(rd_data == 16'h0, "R1", "rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mdc && !busy && !mdo_en, "R1", "idle after reset", {mdc, busy, mdo_en}, 0);

        // R2..R7: read and write frames with varied fields and dividers
        send(0, 5'h00, 5'h01, 16'h0000, 16'hA5C3, 2);
        drain();
        send(1, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1);
        drain();
        check(rd_data == 16'hA5C3, "R12", "rd_data after write", rd_data, 16'hA5C3);
        send(0, 5'h15, 5'h0A, 16'h0000, 16'hFFFF, 0);
        drain();
        send(0, 5'h0A, 5'h15, 16'h0000, 16'h0001, 3);
        drain();
        send(1, 5'h03, 5'h1E, 16'h7E5A, 16'h0000, 2);

        // R8: divider change mid-frame must not alter the running frame
        repeat (20) @(negedge clk);
        half_div = 16'd5;
        drain();

        // R10: command strobe while busy is ignored
        send(0, 5'h11, 5'h12, 16'h0000, 16'h3C96, 2);
        repeat (40) @(negedge clk);
        cmd_write = 1; cmd_phy = 5'h1F; cmd_reg = 5'h1F; cmd_wdata = 16'hFFFF;
        half_div = 16'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        check(!busy && !mdc, "R10", "no extra frame after ignored command", {busy, mdc}, 0);

        // R11: new command in the done cycle
        send(1, 5'h05, 5'h06, 16'h1234, 16'h0000, 1);
        @(negedge clk);
        while (!done) @(negedge clk);
        check(!busy, "R11", "busy low in done cycle", busy, 0);
        send_now(0, 5'h09, 5'h0C, 16'h0000, 16'hBEEF, 1);
        check(busy, "R11", "frame started right after done", busy, 1);
        drain();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule